// File: doc/BRIEF.md
# Symbol Error Pattern Applier

This block sits behind a Reed-Solomon style error locator. The locator has already found up to four faulty 12-bit symbols in a stored page: 2048 data bytes followed by a 64-byte spare area whose first 14 bytes hold check bytes. The locator hands over each faulty symbol as a pair, a symbol position and a 12-bit error pattern. The block translates every position into the one or two bytes that the symbol covers, then fixes those bytes in place. For each byte it reads the byte from the page buffer, XORs in the matching slice of the pattern and writes the result back.

The buffer is seen as one flat byte space. Addresses 0 to 2047 are data and addresses 2048 and up are spare bytes. Symbols pack 12 bits into one and a half bytes, most significant bit first. Symbol 0 is short: only its low 8 bits land in the page. One symbol, position 1365, straddles the data/spare boundary. A run starts with a one-cycle `start` and ends with a one-cycle `done`. At `done` the block reports how many pairs it applied, or flags the page as uncorrectable.

Top module: `sym_fix_applier`

## Requirements
- R1: After reset, `busy`, `done`, `uncorrectable`, `fixed_count`, `buf_rd_en` and `buf_wr_en` are all 0.
- R2: For an odd position p, pattern bits 11:4 are XORed into byte floor(3p/2), and pattern bits 3:0 are XORed into bits 7:4 of the next byte.
- R3: For an even, nonzero position p, pattern bits 11:8 are XORed into bits 3:0 of byte floor(3p/2)-1, and pattern bits 7:0 are XORed into byte floor(3p/2).
- R4: For position 0 with a pattern of at most 0xFF, the pattern is XORed into byte 0. For position 0 with a pattern above 0xFF, the page is uncorrectable.
- R5: A position above 1374 marks the page uncorrectable.
- R6: Spare bytes sit at buffer address 2048 plus their offset. Position 1365 fixes data byte 2047 and the upper nibble of address 2048. No access ever goes above address 2061.
- R7: Each byte update reads an address in one cycle. The buffer returns `buf_rdata` one cycle after the read. In that cycle the block writes the same address with the read data XOR the pattern slice. Read and write are never asserted together.
- R8: Pairs are taken in index order, pair i sitting at bits 12i+11:12i of `sym_pos` and `sym_pat`. Only the first `pair_count` pairs are used, and a `pair_count` above 4 counts as 4. On success, `fixed_count` equals the number of pairs used.
- R9: On the first failing pair the run stops. The pairs before it stay applied, the failing pair and all later pairs make no write, `uncorrectable` is 1, and `fixed_count` holds the number of pairs applied.
- R10: `done` is high for exactly one cycle. `uncorrectable` and `fixed_count` hold until the next accepted start. A `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; sampled only while idle |
| pair_count | input | 3 | Number of valid pairs |
| sym_pos | input | 48 | Four 12-bit symbol positions, pair 0 in the low bits |
| sym_pat | input | 48 | Four 12-bit error patterns, same packing |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| uncorrectable | output | 1 | The last run hit an invalid pair |
| fixed_count | output | 3 | Pairs applied in the last run |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_addr | output | 12 | Buffer byte address |
| buf_wdata | output | 8 | Corrected byte to write |
| buf_rdata | input | 8 | Byte returned one cycle after a read |

## Verification
The assertions assume the buffer answers every read with exactly one cycle of latency. They also assume `sym_pos` and `sym_pat` only matter at the cycle a start is accepted. The bench models a synchronous byte memory with that latency. It changes the pair inputs only together with `start`, and it fires a stray `start` in mid-run on purpose to show it is ignored. Expected page contents come from a bit-stream view of the symbols: symbol p covers stream bits 12p-4 to 12p+7. This is a different formulation from the byte arithmetic in the RTL.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

  localparam int SYM_W       = 12;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 12;
  localparam int DATA_BYTES  = 2048;
  localparam int SPARE_BYTES = 64;
  localparam int MAX_POS     = 1374;
  localparam int LAST_ADDR   = MAX_POS + MAX_POS / 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_RD0,
    ST_WR0,
    ST_RD1,
    ST_WR1,
    ST_FIN
  } seq_state_e;

  typedef struct packed {
    logic              bad;
    logic              two;
    logic [ADDR_W-1:0] addr0;
    logic [BYTE_W-1:0] mask0;
    logic [BYTE_W-1:0] mask1;
  } fix_plan_t;

  // floor(3p/2) written as p + floor(p/2)
  function automatic logic [ADDR_W-1:0] mid_byte(input logic [SYM_W-1:0] pos);
    return pos + {1'b0, pos[SYM_W-1:1]};
  endfunction

  function automatic fix_plan_t plan_pair(input logic [SYM_W-1:0] pos,
                                          input logic [SYM_W-1:0] pat);
    fix_plan_t pl;
    logic [ADDR_W-1:0] mb;
    mb = mid_byte(pos);
    pl = '0;
    if (pos > SYM_W'(MAX_POS)) begin
      pl.bad = 1'b1;
    end else if (pos == '0) begin
      pl.bad   = |pat[SYM_W-1:BYTE_W];
      pl.two   = 1'b0;
      pl.addr0 = '0;
      pl.mask0 = pat[BYTE_W-1:0];
    end else if (pos[0]) begin
      pl.two   = 1'b1;
      pl.addr0 = mb;
      pl.mask0 = pat[SYM_W-1:4];
      pl.mask1 = {pat[3:0], 4'h0};
    end else begin
      pl.two   = 1'b1;
      pl.addr0 = mb - 1'b1;
      pl.mask0 = {4'h0, pat[SYM_W-1:BYTE_W]};
      pl.mask1 = pat[BYTE_W-1:0];
    end
    return pl;
  endfunction

endpackage

// File: rtl/sfa_sym_map.sv
module sfa_sym_map
  import sfa_pkg::*;
(
  input  logic [SYM_W-1:0] pos,
  input  logic [SYM_W-1:0] pat,
  output fix_plan_t        plan
);

  always_comb begin
    plan = plan_pair(pos, pat);
  end

endmodule

// File: rtl/sfa_rmw_seq.sv
module sfa_rmw_seq
  import sfa_pkg::*;
#(
  parameter int NPAIR = 4,
  localparam int CNT_W = $clog2(NPAIR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CNT_W-1:0]  n_eff,
  input  fix_plan_t         plan,
  input  logic [BYTE_W-1:0] rdata,
  output logic [CNT_W-1:0]  idx,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              rd_en,
  output logic              wr_en,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] wdata
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d, n_q;
  logic             fail_q, fail_d;
  logic             pair_end;   // last byte of the current pair written
  logic             list_end;   // every requested pair consumed

  assign list_end = (idx_q == n_q);
  assign pair_end = (state_q == ST_WR1) || (state_q == ST_WR0 && !plan.two);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    fail_d  = fail_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_PICK;
        idx_d   = '0;
        fail_d  = 1'b0;
      end
      ST_PICK: begin
        if (list_end) begin
          state_d = ST_FIN;
        end else if (plan.bad) begin
          fail_d  = 1'b1;
          state_d = ST_FIN;
        end else begin
          state_d = ST_RD0;
        end
      end
      ST_RD0:  state_d = ST_WR0;
      ST_WR0:  state_d = plan.two ? ST_RD1 : ST_PICK;
      ST_RD1:  state_d = ST_WR1;
      ST_WR1:  state_d = ST_PICK;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (pair_end) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      n_q     <= '0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      fail_q  <= fail_d;
      if (accept && state_q == ST_IDLE) n_q <= n_eff;
    end
  end

  always_comb begin
    rd_en = (state_q == ST_RD0) || (state_q == ST_RD1);
    wr_en = (state_q == ST_WR0) || (state_q == ST_WR1);
    addr  = (state_q == ST_RD1 || state_q == ST_WR1) ? plan.addr0 + 1'b1 : plan.addr0;
    wdata = rdata ^ ((state_q == ST_WR1) ? plan.mask1 : plan.mask0);
  end

  assign idx  = idx_q;
  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_FIN);
  assign fail = fail_q;

  AST_RMW_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(rd_en) && addr == $past(addr))); // R7
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)); // R7
  AST_ADDR_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> (addr <= ADDR_W'(LAST_ADDR))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_FAIL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> !wr_en); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q <= n_q)); // R8
  AST_NO_BAD_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD0) |-> !plan.bad); // R5

endmodule

// File: rtl/sym_fix_applier.sv
module sym_fix_applier
  import sfa_pkg::*;
#(
  parameter int NPAIR = 4,
  localparam int CNT_W = $clog2(NPAIR + 1),
  localparam int SEL_W = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CNT_W-1:0]       pair_count,
  input  logic [NPAIR*SYM_W-1:0] sym_pos,
  input  logic [NPAIR*SYM_W-1:0] sym_pat,
  output logic                   busy,
  output logic                   done,
  output logic                   uncorrectable,
  output logic [CNT_W-1:0]       fixed_count,
  output logic                   buf_rd_en,
  output logic                   buf_wr_en,
  output logic [ADDR_W-1:0]      buf_addr,
  output logic [BYTE_W-1:0]      buf_wdata,
  input  logic [BYTE_W-1:0]      buf_rdata
);

  logic             accept;       // start taken while idle
  logic [CNT_W-1:0] n_eff;        // pair count clamped to NPAIR
  logic [CNT_W-1:0] cur_idx;
  logic [SYM_W-1:0] pos_q [NPAIR];
  logic [SYM_W-1:0] pat_q [NPAIR];
  fix_plan_t        plans [NPAIR];
  fix_plan_t        cur_plan;

  assign accept = start && !busy;
  assign n_eff  = (pair_count > CNT_W'(NPAIR)) ? CNT_W'(NPAIR) : pair_count;

  for (genvar gi = 0; gi < NPAIR; gi++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos_q[gi] <= '0;
        pat_q[gi] <= '0;
      end else if (accept) begin
        pos_q[gi] <= sym_pos[gi*SYM_W +: SYM_W];
        pat_q[gi] <= sym_pat[gi*SYM_W +: SYM_W];
      end
    end

    sfa_sym_map u_map (
      .pos  (pos_q[gi]),
      .pat  (pat_q[gi]),
      .plan (plans[gi])
    );
  end

  always_comb begin
    cur_plan = '0;
    if (cur_idx < CNT_W'(NPAIR)) cur_plan = plans[cur_idx[SEL_W-1:0]];
  end

  sfa_rmw_seq #(.NPAIR(NPAIR)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .accept(accept),
    .n_eff (n_eff),
    .plan  (cur_plan),
    .rdata (buf_rdata),
    .idx   (cur_idx),
    .busy  (busy),
    .done  (done),
    .fail  (uncorrectable),
    .rd_en (buf_rd_en),
    .wr_en (buf_wr_en),
    .addr  (buf_addr),
    .wdata (buf_wdata)
  );

  assign fixed_count = cur_idx;

  AST_BUSY_HOLDS_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(pos_q[0]) && $stable(pat_q[0])); // R10
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_count <= CNT_W'(NPAIR)); // R8

endmodule

// File: tb/sym_fix_applier_bench.sv
module sym_fix_applier_bench;

  localparam int NB = 2112;
  localparam int NV = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  pair_count = '0;
  logic [47:0] sym_pos = '0;
  logic [47:0] sym_pat = '0;
  logic        busy, done, uncorrectable, buf_rd_en, buf_wr_en;
  logic [2:0]  fixed_count;
  logic [11:0] buf_addr;
  logic [7:0]  buf_wdata;
  logic [7:0]  buf_rdata = '0;

  logic [7:0]  mem     [NB];
  logic [7:0]  exp_mem [NB];
  logic        exp_fail;
  int          exp_cnt;
  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;
  int          port_bad = 0;
  int          span_bad = 0;
  logic        prev_rd = 1'b0;
  logic [11:0] prev_addr = '0;

  always #5 clk = ~clk;

  sym_fix_applier u_sym_fix_applier (
    .clk(clk), .rst_n(rst_n), .start(start), .pair_count(pair_count),
    .sym_pos(sym_pos), .sym_pat(sym_pat), .busy(busy), .done(done),
    .uncorrectable(uncorrectable), .fixed_count(fixed_count),
    .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
  );

  // buffer model with one cycle of read latency, plus a port monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (buf_rd_en) buf_rdata <= mem[buf_addr];
    if (buf_wr_en) mem[buf_addr] <= buf_wdata;
    if (buf_wr_en && (!prev_rd || prev_addr != buf_addr)) port_bad <= port_bad + 1;
    if (buf_wr_en && buf_rd_en) port_bad <= port_bad + 1;
    if ((buf_wr_en || buf_rd_en) && buf_addr > 12'd2061) span_bad <= span_bad + 1;
    prev_rd   <= buf_rd_en;
    prev_addr <= buf_addr;
  end

  always @(negedge clk) begin
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycles=%0d expected < 100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // entry: {count, pos3, pos2, pos1, pos0, pat3, pat2, pat1, pat0}
  localparam logic [98:0] VEC [NV] = '{
    {3'd1, 12'd0, 12'd0, 12'd0, 12'd1, 12'h0, 12'h0, 12'h0, 12'hABC},          // R2
    {3'd2, 12'd0, 12'd0, 12'd1365, 12'd2, 12'h0, 12'h0, 12'hFED, 12'h123},     // R3 R6
    {3'd3, 12'd0, 12'd1366, 12'd1374, 12'd0, 12'h0, 12'h9C3, 12'h777, 12'h0A5}, // R4 R6
    {3'd4, 12'd681, 12'd1000, 12'd4, 12'd3, 12'h800, 12'h0F1, 12'hC3C, 12'h5A5}, // R2 R3 R8
    {3'd3, 12'd0, 12'd7, 12'd1375, 12'd5, 12'h0, 12'h222, 12'hFFF, 12'h111},   // R5 R9
    {3'd2, 12'd0, 12'd0, 12'd3, 12'd0, 12'h0, 12'h0, 12'h123, 12'h100},        // R4 R9
    {3'd0, 12'd9, 12'd9, 12'd9, 12'd9, 12'h1, 12'h1, 12'h1, 12'h1},            // R8
    {3'd2, 12'd0, 12'd0, 12'd10, 12'd10, 12'h0, 12'h0, 12'hFFF, 12'hFFF},      // R8
    {3'd7, 12'd9, 12'd7, 12'd2, 12'd1365, 12'h4, 12'h3, 12'h2, 12'h1}          // R8 clamp
  };

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < NB; i++) begin
      mem[i]     = 8'(i * 7) ^ 8'h5A;
      exp_mem[i] = 8'(i * 7) ^ 8'h5A;
    end
  endtask

  // symbol p covers stream bits 12p-4 .. 12p+7, most significant bit first
  task automatic model(input logic [2:0] n, input logic [47:0] pv, input logic [47:0] qv);
    int ne;
    ne = (n > 3'd4) ? 4 : int'(n);
    exp_fail = 1'b0;
    exp_cnt  = 0;
    for (int i = 0; i < ne; i++) begin
      int p;
      logic [11:0] q;
      p = int'(pv[12*i +: 12]);
      q = qv[12*i +: 12];
      if (p > 1374 || (p == 0 && q[11:8] != 4'h0)) begin
        exp_fail = 1'b1;
        break;
      end
      for (int k = 0; k < 12; k++) begin
        int b;
        b = 12 * p - 4 + k;
        if (b >= 0 && q[11-k]) exp_mem[b/8][7-(b%8)] = ~exp_mem[b/8][7-(b%8)];
      end
      exp_cnt = exp_cnt + 1;
    end
  endtask

  task automatic run(input logic [2:0] n, input logic [47:0] pv, input logic [47:0] qv);
    int t;
    @(negedge clk);
    pair_count = n; sym_pos = pv; sym_pat = qv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 200) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic compare(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < NB; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, req, bad, 0);
    chk(uncorrectable === exp_fail, req, int'(uncorrectable), int'(exp_fail));
    chk(int'(fixed_count) == exp_cnt, req, int'(fixed_count), exp_cnt);
  endtask

  initial begin
    fill_mem();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !uncorrectable && fixed_count == 3'd0 && !buf_rd_en && !buf_wr_en,
        "R1", int'({busy, done, uncorrectable, buf_rd_en, buf_wr_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !buf_rd_en && !buf_wr_en, "R1", int'(busy), 0);

    // R2 R3 R4 R5 R6 R8 R9: table of vectors
    for (int v = 0; v < NV; v++) begin
      fill_mem();
      model(VEC[v][98:96], VEC[v][95:48], VEC[v][47:0]);
      run(VEC[v][98:96], VEC[v][95:48], VEC[v][47:0]);
      chk(done === 1'b1, "R10", int'(done), 1);
      compare($sformatf("R2/R3/R4/R5/R6/R8/R9 vector %0d", v));
      @(negedge clk);
      chk(done === 1'b0, "R10", int'(done), 0);
    end

    // R6: spot check of the boundary bytes for position 1365 pattern FED
    fill_mem();
    run(3'd1, {36'd0, 12'd1365}, {36'd0, 12'hFED});
    chk(mem[2047] == ((8'(2047 * 7) ^ 8'h5A) ^ 8'hFE), "R6", int'(mem[2047]), 0);
    chk(mem[2048] == ((8'(2048 * 7) ^ 8'h5A) ^ 8'hD0), "R6", int'(mem[2048]), 0);

    // R10: start while busy is ignored, results hold after done
    fill_mem();
    model(VEC[3][98:96], VEC[3][95:48], VEC[3][47:0]);
    @(negedge clk);
    pair_count = VEC[3][98:96]; sym_pos = VEC[3][95:48]; sym_pat = VEC[3][47:0]; start = 1'b1;
    @(negedge clk);
    pair_count = VEC[0][98:96]; sym_pos = VEC[0][95:48]; sym_pat = VEC[0][47:0];
    chk(busy === 1'b1, "R10", int'(busy), 1);
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 200 && !done; t++) @(negedge clk);
    compare("R10 start while busy");
    repeat (4) @(negedge clk);
    chk(!busy && !buf_wr_en && !buf_rd_en, "R10", int'(busy), 0);
    compare("R10 hold");

    // R7 R6: port monitor totals
    chk(port_bad == 0, "R7", port_bad, 0);
    chk(span_bad == 0, "R6", span_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule